// File: doc/BRIEF.md
# SPI Configuration Sequencer

This block brings an attached peripheral to its working state through an external SPI master, with no help from software. After reset it runs a fixed series of commands. It first sends a reset instruction. It then sends one register write per step, where the target address and the value come from a constant table. A single step counter serves as the read index into that table. After the writes it sends a status inquiry. Each command goes to the serialiser as an instruction byte, an address byte, a data byte and a byte count. The handshake is a one-clock start and a one-clock done, and a new command is never issued until the previous one has completed.

If the status byte returned by the peripheral matches the expected value, the block raises a sticky ready flag and enters normal operation. From then on, commands come from a request port and are accepted only while no transfer is in flight. Each finished request returns the byte received from the peripheral. If the status byte does not match, the block pulses an error flag and runs the whole series again from the reset instruction.

Top module: `spi_cfg_seq`

## Requirements
- R1: The first command after reset is the reset instruction 0xC0 with byte count 1 and address and data 0x00.
- R2: Steps 1 to NUM_WRITES (default 10) each issue write instruction 0x02 with byte count 3. The address is bits 15:8 and the data is bits 7:0 of the table word whose index equals the step. With the default table, steps 1..10 hold 0x2A/0x4C, 0x29/0xCC, 0x28/0xAA, and then 0x20, 0x21, 0x00, 0x01, 0x04, 0x05, 0x24, each with 0xFF.
- R3: spiStart is high for exactly one clock per command. busy is high from the start pulse until the clock after spiDone, and no further start occurs in that interval.
- R4: After the writes, the status inquiry 0x05 is issued with address STATUS_ADDR (0x0E), data 0x00 and byte count 3. If spiRxByte equals STATUS_OK (0x80) at done, cfgReady goes high on the next clock and stays high.
- R5: If the status byte differs from STATUS_OK, cfgError is high for exactly one clock after done, cfgReady stays low, and the series restarts with the reset instruction.
- R6: reqAccept equals reqValid while cfgReady is high and busy is low. The next clock after an accepted request issues its instruction, address and data with byte count 1 when the instruction is 0xC0 and 3 otherwise.
- R7: Before cfgReady rises, requests are ignored: reqAccept stays low and the commands issued are only those of the configuration series.
- R8: After an accepted request completes, rspValid is high for one clock after spiDone, with rspData equal to spiRxByte at done.
- R9: During reset, spiStart, busy, cfgReady, cfgError, reqAccept and rspValid are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| spiStart | output | 1 | One-clock command start to the SPI master |
| spiInstr | output | 8 | Instruction byte of the command |
| spiAddr | output | 8 | Address byte of the command |
| spiData | output | 8 | Data byte of the command |
| spiLen | output | 3 | Number of bytes in the frame |
| spiDone | input | 1 | One-clock completion from the SPI master |
| spiRxByte | input | 8 | Byte returned by the peripheral, valid with spiDone |
| reqValid | input | 1 | External command request |
| reqInstr | input | 8 | Requested instruction |
| reqAddr | input | 8 | Requested address |
| reqData | input | 8 | Requested data |
| reqAccept | output | 1 | Request taken this clock |
| busy | output | 1 | A transfer is in flight |
| cfgReady | output | 1 | Configuration finished, normal operation |
| cfgError | output | 1 | One-clock pulse on a bad status byte |
| rspValid | output | 1 | Reply to an external request is valid |
| rspData | output | 8 | Reply byte |

## Verification
The checker watches the handshake rules on every cycle. These are the single-clock start, start only while busy is high, busy falling only after a done, the sticky ready flag, the single-clock error pulse, the accept condition and the timing of the reply. Only the bench scenarios can show the command contents: the exact order of the reset, write and status commands against the table, the full replay after a bad status byte, the byte counts chosen for external requests, and the reply data.

// File: rtl/spi_cfg_seq_pkg.sv
package spi_cfg_seq_pkg;

  localparam int BYTE_W = 8;
  localparam int LEN_W  = 3;
  localparam int WORD_W = 2 * BYTE_W;

  localparam logic [BYTE_W-1:0] OP_RESET  = 8'hC0;
  localparam logic [BYTE_W-1:0] OP_WRITE  = 8'h02;
  localparam logic [BYTE_W-1:0] OP_STATUS = 8'h05;

  localparam logic [LEN_W-1:0] LEN_SHORT = 3'd1;
  localparam logic [LEN_W-1:0] LEN_FRAME = 3'd3;

  typedef enum logic [1:0] {
    ST_ISSUE,
    ST_WAIT,
    ST_IDLE,
    ST_XFER
  } seqState_t;

  typedef struct packed {
    logic loadCfg;
    logic loadExt;
    logic stepInc;
    logic stepClr;
    logic setReady;
    logic raiseErr;
    logic captureRsp;
  } seqCtl_t;

  // Table word: upper byte = register address, lower byte = value.
  function automatic logic [WORD_W-1:0] tableWord(input int unsigned idx);
    case (idx)
      1:       return 16'h2A4C;
      2:       return 16'h29CC;
      3:       return 16'h28AA;
      4:       return 16'h20FF;
      5:       return 16'h21FF;
      6:       return 16'h00FF;
      7:       return 16'h01FF;
      8:       return 16'h04FF;
      9:       return 16'h05FF;
      10:      return 16'h24FF;
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/spi_cfg_seq_rom.sv
module spi_cfg_seq_rom
  import spi_cfg_seq_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [IDX_W-1:0]  idx,
  output logic [WORD_W-1:0] word
);

  logic [WORD_W-1:0] contents [DEPTH];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_word
    assign contents[gi] = tableWord(gi);
  end

  assign word = contents[idx];

endmodule

// File: rtl/spi_cfg_seq_dpath.sv
module spi_cfg_seq_dpath
  import spi_cfg_seq_pkg::*;
#(
  parameter int               DEPTH       = 32,
  parameter int               NUM_WRITES  = 10,
  parameter logic [BYTE_W-1:0] STATUS_ADDR = 8'h0E,
  parameter logic [BYTE_W-1:0] STATUS_OK   = 8'h80,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtl_t           ctl,
  input  logic [BYTE_W-1:0] spiRxByte,
  input  logic [BYTE_W-1:0] reqInstr,
  input  logic [BYTE_W-1:0] reqAddr,
  input  logic [BYTE_W-1:0] reqData,
  output logic              isStatusStep,
  output logic              statusOk,
  output logic              spiStart,
  output logic [BYTE_W-1:0] spiInstr,
  output logic [BYTE_W-1:0] spiAddr,
  output logic [BYTE_W-1:0] spiData,
  output logic [LEN_W-1:0]  spiLen,
  output logic              cfgReady,
  output logic              cfgError,
  output logic              rspValid,
  output logic [BYTE_W-1:0] rspData
);

  localparam logic [IDX_W-1:0] STATUS_STEP = IDX_W'(NUM_WRITES + 1);

  logic [IDX_W-1:0]  step;
  logic [WORD_W-1:0] romWord;
  logic [BYTE_W-1:0] cfgInstr, cfgAddr, cfgData;
  logic [LEN_W-1:0]  cfgLen, extLen;

  spi_cfg_seq_rom #(.DEPTH(DEPTH)) i_rom (
    .idx  (step),
    .word (romWord)
  );

  always_comb begin
    if (step == '0) begin
      cfgInstr = OP_RESET;
      cfgAddr  = '0;
      cfgData  = '0;
      cfgLen   = LEN_SHORT;
    end else if (step == STATUS_STEP) begin
      cfgInstr = OP_STATUS;
      cfgAddr  = STATUS_ADDR;
      cfgData  = '0;
      cfgLen   = LEN_FRAME;
    end else begin
      cfgInstr = OP_WRITE;
      cfgAddr  = romWord[WORD_W-1:BYTE_W];
      cfgData  = romWord[BYTE_W-1:0];
      cfgLen   = LEN_FRAME;
    end
  end

  assign extLen       = (reqInstr == OP_RESET) ? LEN_SHORT : LEN_FRAME;
  assign isStatusStep = (step == STATUS_STEP);
  assign statusOk     = (spiRxByte == STATUS_OK);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      step     <= '0;
      spiStart <= 1'b0;
      spiInstr <= '0;
      spiAddr  <= '0;
      spiData  <= '0;
      spiLen   <= '0;
      cfgReady <= 1'b0;
      cfgError <= 1'b0;
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      spiStart <= ctl.loadCfg | ctl.loadExt;
      if (ctl.loadCfg) begin
        spiInstr <= cfgInstr;
        spiAddr  <= cfgAddr;
        spiData  <= cfgData;
        spiLen   <= cfgLen;
      end else if (ctl.loadExt) begin
        spiInstr <= reqInstr;
        spiAddr  <= reqAddr;
        spiData  <= reqData;
        spiLen   <= extLen;
      end
      if (ctl.stepClr)      step <= '0;
      else if (ctl.stepInc) step <= step + 1'b1;
      cfgReady <= cfgReady | ctl.setReady;
      cfgError <= ctl.raiseErr;
      rspValid <= ctl.captureRsp;
      if (ctl.captureRsp) rspData <= spiRxByte;
    end
  end

endmodule

// File: rtl/spi_cfg_seq_ctrl.sv
module spi_cfg_seq_ctrl
  import spi_cfg_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    spiDone,
  input  logic    reqValid,
  input  logic    isStatusStep,
  input  logic    statusOk,
  output seqCtl_t ctl,
  output logic    reqAccept,
  output logic    busy
);

  seqState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_ISSUE;
    else       state <= nextState;
  end

  always_comb begin
    ctl       = '0;
    nextState = state;
    case (state)
      ST_ISSUE: begin
        ctl.loadCfg = 1'b1;
        nextState   = ST_WAIT;
      end
      ST_WAIT: begin
        if (spiDone) begin
          if (!isStatusStep) begin
            ctl.stepInc = 1'b1;
            nextState   = ST_ISSUE;
          end else if (statusOk) begin
            ctl.setReady = 1'b1;
            nextState    = ST_IDLE;
          end else begin
            ctl.raiseErr = 1'b1;
            ctl.stepClr  = 1'b1;
            nextState    = ST_ISSUE;
          end
        end
      end
      ST_IDLE: begin
        if (reqValid) begin
          ctl.loadExt = 1'b1;
          nextState   = ST_XFER;
        end
      end
      ST_XFER: begin
        if (spiDone) begin
          ctl.captureRsp = 1'b1;
          nextState      = ST_IDLE;
        end
      end
      default: nextState = ST_ISSUE;
    endcase
  end

  assign reqAccept = (state == ST_IDLE) && reqValid;
  assign busy      = (state == ST_WAIT) || (state == ST_XFER);

endmodule

// File: rtl/spi_cfg_seq.sv
module spi_cfg_seq
  import spi_cfg_seq_pkg::*;
#(
  parameter int               TABLE_DEPTH = 32,
  parameter int               NUM_WRITES  = 10,
  parameter logic [7:0]       STATUS_ADDR = 8'h0E,
  parameter logic [7:0]       STATUS_OK   = 8'h80
) (
  input  logic       clk,
  input  logic       rstN,
  output logic       spiStart,
  output logic [7:0] spiInstr,
  output logic [7:0] spiAddr,
  output logic [7:0] spiData,
  output logic [2:0] spiLen,
  input  logic       spiDone,
  input  logic [7:0] spiRxByte,
  input  logic       reqValid,
  input  logic [7:0] reqInstr,
  input  logic [7:0] reqAddr,
  input  logic [7:0] reqData,
  output logic       reqAccept,
  output logic       busy,
  output logic       cfgReady,
  output logic       cfgError,
  output logic       rspValid,
  output logic [7:0] rspData
);

  seqCtl_t ctl;
  logic    isStatusStep;
  logic    statusOk;

  spi_cfg_seq_ctrl i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .spiDone      (spiDone),
    .reqValid     (reqValid),
    .isStatusStep (isStatusStep),
    .statusOk     (statusOk),
    .ctl          (ctl),
    .reqAccept    (reqAccept),
    .busy         (busy)
  );

  spi_cfg_seq_dpath #(
    .DEPTH       (TABLE_DEPTH),
    .NUM_WRITES  (NUM_WRITES),
    .STATUS_ADDR (STATUS_ADDR),
    .STATUS_OK   (STATUS_OK)
  ) i_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .spiRxByte    (spiRxByte),
    .reqInstr     (reqInstr),
    .reqAddr      (reqAddr),
    .reqData      (reqData),
    .isStatusStep (isStatusStep),
    .statusOk     (statusOk),
    .spiStart     (spiStart),
    .spiInstr     (spiInstr),
    .spiAddr      (spiAddr),
    .spiData      (spiData),
    .spiLen       (spiLen),
    .cfgReady     (cfgReady),
    .cfgError     (cfgError),
    .rspValid     (rspValid),
    .rspData      (rspData)
  );

endmodule

// File: rtl/spi_cfg_seq_chk.sv
module spi_cfg_seq_chk (
  input logic clk,
  input logic rstN,
  input logic spiStart,
  input logic spiDone,
  input logic busy,
  input logic cfgReady,
  input logic cfgError,
  input logic reqValid,
  input logic reqAccept,
  input logic rspValid
);

  // R3
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    spiStart |=> !spiStart);

  // R3
  start_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    spiStart |-> busy);

  // R3
  busy_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(spiDone));

  // R4
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgReady |=> cfgReady);

  // R5
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgError |=> !cfgError);

  // R5
  err_not_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgError |-> !cfgReady);

  // R6
  accept_cond_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqAccept |-> (reqValid && cfgReady && !busy));

  // R7
  cfg_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgReady |-> !reqAccept);

  // R8
  rsp_after_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (cfgReady && $past(spiDone)));

endmodule

bind spi_cfg_seq spi_cfg_seq_chk i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .spiStart  (spiStart),
  .spiDone   (spiDone),
  .busy      (busy),
  .cfgReady  (cfgReady),
  .cfgError  (cfgError),
  .reqValid  (reqValid),
  .reqAccept (reqAccept),
  .rspValid  (rspValid)
);

// File: tb/test_spi_cfg_seq.sv
module test_spi_cfg_seq;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       spiStart, reqAccept, busy, cfgReady, cfgError, rspValid;
  logic [7:0] spiInstr, spiAddr, spiData, rspData;
  logic [2:0] spiLen;
  logic       spiDone = 1'b0;
  logic [7:0] spiRxByte = 8'h00;
  logic       reqValid = 1'b0;
  logic [7:0] reqInstr = 8'h00, reqAddr = 8'h00, reqData = 8'h00;

  int nTests = 0;
  int nFail  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  spi_cfg_seq i_spi_cfg_seq (
    .clk(clk), .rstN(rstN), .spiStart(spiStart), .spiInstr(spiInstr),
    .spiAddr(spiAddr), .spiData(spiData), .spiLen(spiLen), .spiDone(spiDone),
    .spiRxByte(spiRxByte), .reqValid(reqValid), .reqInstr(reqInstr),
    .reqAddr(reqAddr), .reqData(reqData), .reqAccept(reqAccept), .busy(busy),
    .cfgReady(cfgReady), .cfgError(cfgError), .rspValid(rspValid),
    .rspData(rspData)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Expected table contents from R2
  function automatic logic [15:0] expWord(input int i);
    logic [7:0] a [10] = '{8'h2A, 8'h29, 8'h28, 8'h20, 8'h21,
                           8'h00, 8'h01, 8'h04, 8'h05, 8'h24};
    logic [7:0] d;
    d = (i == 1) ? 8'h4C : (i == 2) ? 8'hCC : (i == 3) ? 8'hAA : 8'hFF;
    return {a[i-1], d};
  endfunction

  // Wait for a start, check the command, then answer with rx after a random delay.
  task automatic serveCmd(input string req, input logic [7:0] eI, input logic [7:0] eA,
                          input logic [7:0] eD, input logic [2:0] eL, input logic [7:0] rx);
    int n = 0;
    bit extra = 1'b0;
    while (!spiStart && n < 40) begin
      @(negedge clk);
      n++;
    end
    chk({req, " start seen"}, spiStart, 1'b1);
    chk({req, " instr"}, spiInstr, eI);
    chk({req, " addr"},  spiAddr,  eA);
    chk({req, " data"},  spiData,  eD);
    chk({req, " len"},   spiLen,   eL);
    chk("R3 busy during transfer", busy, 1'b1);
    repeat (1 + $urandom % 4) begin
      @(negedge clk);
      if (spiStart) extra = 1'b1;
    end
    chk("R3 no start before done", extra, 1'b0);
    spiDone   = 1'b1;
    spiRxByte = rx;
    @(negedge clk);
    spiDone = 1'b0;
    chk("R3 busy released", busy, 1'b0);
  endtask

  task automatic runConfig(input string firstTag, input logic [7:0] statusByte);
    serveCmd(firstTag, 8'hC0, 8'h00, 8'h00, 3'd1, 8'($urandom));
    chk("R7 no accept during config", reqAccept, 1'b0);
    for (int i = 1; i <= 10; i++) begin
      logic [15:0] w;
      w = expWord(i);
      reqInstr = 8'($urandom);
      reqAddr  = 8'($urandom);
      reqData  = 8'($urandom);
      serveCmd("R2", 8'h02, w[15:8], w[7:0], 3'd3, 8'($urandom));
      chk("R7 no accept during config", reqAccept, 1'b0);
    end
    reqValid = 1'b0;
    serveCmd("R4", 8'h05, 8'h0E, 8'h00, 3'd3, statusByte);
  endtask

  initial begin
    void'($urandom(32'd1234));
    // R9 reset state
    repeat (3) @(negedge clk);
    chk("R9 spiStart", spiStart, 1'b0);
    chk("R9 busy", busy, 1'b0);
    chk("R9 cfgReady", cfgReady, 1'b0);
    chk("R9 cfgError", cfgError, 1'b0);
    chk("R9 reqAccept", reqAccept, 1'b0);
    chk("R9 rspValid", rspValid, 1'b0);
    rstN = 1'b1;

    // Round 1: requests held during config, status byte wrong
    reqValid = 1'b1;
    runConfig("R1", 8'h3C);
    chk("R5 error pulse", cfgError, 1'b1);
    chk("R5 not ready", cfgReady, 1'b0);
    @(negedge clk);
    chk("R5 error one clock", cfgError, 1'b0);

    // Round 2: replay from the reset instruction, good status
    reqValid = 1'b1;
    runConfig("R5 restart", 8'h80);
    chk("R4 ready after status", cfgReady, 1'b1);
    chk("R4 no error", cfgError, 1'b0);

    // Normal operation: random requests plus reset-instruction corner case
    for (int k = 0; k < 24; k++) begin
      logic [7:0] ins, ad, da, rx;
      logic [2:0] len;
      ins = (k % 5 == 0) ? 8'hC0 : 8'($urandom);
      ad  = 8'($urandom);
      da  = 8'($urandom);
      rx  = 8'($urandom);
      len = (ins == 8'hC0) ? 3'd1 : 3'd3;
      reqValid = 1'b1; reqInstr = ins; reqAddr = ad; reqData = da;
      #1;
      chk("R6 accept when idle", reqAccept, 1'b1);
      @(negedge clk);
      reqInstr = 8'($urandom);
      #1;
      chk("R6 no accept while busy", reqAccept, 1'b0);
      reqValid = 1'b0;
      serveCmd("R6", ins, ad, da, len, rx);
      chk("R8 rspValid", rspValid, 1'b1);
      chk("R8 rspData", rspData, rx);
      chk("R4 ready held", cfgReady, 1'b1);
      @(negedge clk);
      chk("R8 rspValid one clock", rspValid, 1'b0);
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

endmodule